// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits next to a small 8-bit processor core and takes over the core's register updates whenever a hardware interrupt is entered or a return-from-interrupt instruction runs. The core tells the block when an instruction has just completed. If an enabled request is waiting at that point, the block stalls the core and spends a fixed run of cycles in the entry sequence. During that run it saves the program counter and the flags on the stack and clears the flags. It then points the program counter at the vector byte supplied by the interrupt controller, with the high byte forced to zero, and acknowledges the controller.

A return is announced at an instruction boundary. The block then pops the flags and the program counter over three cycles and loads them back into the core. The flags it restores usually have the global enable bit set. If a request is still pending and the restored flags allow it, the block goes straight into a new entry sequence, so no ordinary instruction runs in between. The stack pointer is kept inside the block. A free-running latency counter restarts when a request becomes enabled, so the delay to the first instruction of the service routine can be read off.

Top module: `irq_seq_top`

## Requirements
- R1: Entry begins only in the cycle after `instr_done` is sampled high while `irq_req` is high and flag bit 0 (global enable) is 1; `core_hold` never rises without `instr_done` high in the cycle before.
- R2: `core_hold` stays high for exactly 13 consecutive cycles per entry sequence.
- R3: Entry writes three bytes to consecutive stack addresses starting at the current stack pointer: first PC[15:8], then PC[7:0], then the flag byte.
- R4: When entry completes, the core's flag register has been loaded with 00h.
- R5: When entry completes, the core's PC has been loaded with {00h, `irq_vec`}.
- R6: `irq_ack` is a single-cycle pulse in the 13th (last) cycle of the entry sequence.
- R7: A return (`ret_req` with `instr_done`) holds the core for 3 cycles and restores the flags and PC from the three topmost stack bytes, leaving the stack pointer where it was before the matching entry.
- R8: When a return restores a flag byte with bit 0 set while `irq_req` is high, a new entry follows at once, with no `instr_done` needed: `core_hold` stays high for 16 cycles in a row and the restored PC and flags are pushed.
- R9: A request at an instruction boundary while flag bit 0 is 0 is ignored: no hold, no stack write, and the stack pointer is unchanged.
- R10: `lat_cycles` becomes 1 in the cycle after an enabled request first appears and then rises by one per cycle, saturating at its maximum. With the request arriving in cycle k of a 5-cycle instruction and a 7-cycle jump after entry, it reads 26-k (21 to 25) in the first cycle of the service routine.
- R11: The 8-bit stack pointer increments after each push and decrements before each pop, wrapping in both directions.
- R12: When `ret_req` and an enabled request meet at the same boundary, the return runs first.
- R13: After reset the stack pointer is 0 and `core_hold`, `irq_ack`, `stk_we`, `pc_load` and `flags_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_done | input | 1 | The current instruction completes in this cycle |
| ret_req | input | 1 | The completing boundary is a return instruction |
| irq_req | input | 1 | Pending request from the interrupt controller |
| irq_vec | input | 8 | Vector byte from the controller |
| irq_ack | output | 1 | Acknowledge pulse to the controller |
| pc_in | input | 16 | Current core program counter |
| flags_in | input | 8 | Current core flag register, bit 0 is global enable |
| pc_load | output | 1 | Load `pc_next` into the core PC |
| pc_next | output | 16 | New PC value |
| flags_load | output | 1 | Load `flags_next` into the flag register |
| flags_next | output | 8 | New flag value |
| stk_we | output | 1 | Stack write strobe |
| stk_waddr | output | 8 | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| stk_raddr | output | 8 | Stack read address (combinational read) |
| stk_rdata | input | 8 | Stack read data |
| sp | output | 8 | Stack pointer |
| core_hold | output | 1 | Core is stalled while the sequencer runs |
| lat_cycles | output | 8 | Cycles since an enabled request appeared |

## Verification
The assertions assume that `instr_done` and `ret_req` are only raised while `core_hold` is low, that the core applies `pc_load` and `flags_load` on the following edge, and that the stack memory returns read data in the same cycle as its address. The stimulus keeps to this by changing inputs only between edges, by pulsing `instr_done` only when the core is free, and by modelling the core registers and a 256-byte stack with those exact timings. Requests are withdrawn in the cycle the acknowledge is seen, as a controller would clear its pending bit.

// File: rtl/irq_seq_pkg.sv
// Package irq_seq_pkg
// Shared types and fixed slot numbers for the interrupt entry/return sequencer.
// Assumes the PC is exactly two data bytes wide.
package irq_seq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_RETURN = 2'd2
    } seq_state_t;

    // Entry step slots; the push order is part of the behaviour
    localparam int SLOT_PUSH_HI  = 0;
    localparam int SLOT_PUSH_LO  = 1;
    localparam int SLOT_PUSH_FLG = 2;
    localparam int SLOT_CLR_FLG  = 3;

    // Return step slots (pops come back in reverse order)
    localparam int SLOT_POP_FLG  = 0;
    localparam int SLOT_POP_LO   = 1;
    localparam int SLOT_POP_HI   = 2;
    localparam int RETURN_STEPS  = 3;

endpackage

// File: rtl/irq_seq_ctrl.sv
// Module irq_seq_ctrl
// Phase and step control for interrupt entry and return. Decides at each
// instruction boundary whether to start a return or an entry, walks a fixed
// number of steps and drives push/pop requests plus PC and flag loads.
// Assumes: instr_done/ret_req only while core_hold is low, stack read data
// valid in the same cycle as its address, ENTRY_LEN > SLOT_CLR_FLG + 1.
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int GIE_BIT   = 0,
    parameter int ENTRY_LEN = 13,
    localparam int PC_W     = 2 * DATA_W,
    localparam int STEP_W   = $clog2(ENTRY_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              ret_req,
    input  logic              irq_req,
    input  logic [DATA_W-1:0] irq_vec,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [DATA_W-1:0] stk_rdata,
    output logic              push_en,
    output logic [DATA_W-1:0] push_data,
    output logic              pop_en,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_next,
    output logic              flags_load,
    output logic [DATA_W-1:0] flags_next,
    output logic              irq_ack,
    output logic              core_hold
);

    localparam logic [STEP_W-1:0] ENTRY_LAST = STEP_W'(ENTRY_LEN - 1);
    localparam logic [STEP_W-1:0] RET_LAST   = STEP_W'(RETURN_STEPS - 1);
    localparam logic [STEP_W-1:0] S_PHI      = STEP_W'(SLOT_PUSH_HI);
    localparam logic [STEP_W-1:0] S_PLO      = STEP_W'(SLOT_PUSH_LO);
    localparam logic [STEP_W-1:0] S_PFL      = STEP_W'(SLOT_PUSH_FLG);
    localparam logic [STEP_W-1:0] S_CLR      = STEP_W'(SLOT_CLR_FLG);
    localparam logic [STEP_W-1:0] S_OFL      = STEP_W'(SLOT_POP_FLG);
    localparam logic [STEP_W-1:0] S_OLO      = STEP_W'(SLOT_POP_LO);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [DATA_W-1:0] flg_buf_q;
    logic [DATA_W-1:0] pcl_buf_q;
    logic              enabled_req;

    assign enabled_req = irq_req && flags_in[GIE_BIT];
    assign core_hold   = (state_q != ST_IDLE);

    // Next phase and step selection
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_done && ret_req) begin
                    state_d = ST_RETURN;
                    step_d  = '0;
                end else if (instr_done && enabled_req) begin
                    state_d = ST_ENTRY;
                    step_d  = '0;
                end
            end
            ST_ENTRY: begin
                if (step_q == ENTRY_LAST) begin
                    state_d = ST_IDLE;
                    step_d  = '0;
                end else begin
                    step_d = step_q + STEP_W'(1);
                end
            end
            ST_RETURN: begin
                if (step_q == RET_LAST) begin
                    step_d  = '0;
                    state_d = (irq_req && flg_buf_q[GIE_BIT]) ? ST_ENTRY : ST_IDLE;
                end else begin
                    step_d = step_q + STEP_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                step_d  = '0;
            end
        endcase
    end

    // Phase and step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Capture popped flag and PC low bytes during return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_buf_q <= '0;
            pcl_buf_q <= '0;
        end else if (state_q == ST_RETURN) begin
            if (step_q == S_OFL) flg_buf_q <= stk_rdata;
            if (step_q == S_OLO) pcl_buf_q <= stk_rdata;
        end
    end

    // Per-step outputs towards the stack, the core and the controller
    always_comb begin
        push_en    = 1'b0;
        push_data  = '0;
        pop_en     = 1'b0;
        pc_load    = 1'b0;
        pc_next    = '0;
        flags_load = 1'b0;
        flags_next = '0;
        irq_ack    = 1'b0;
        if (state_q == ST_ENTRY) begin
            if (step_q == S_PHI) begin
                push_en   = 1'b1;
                push_data = pc_in[PC_W-1:DATA_W];
            end
            if (step_q == S_PLO) begin
                push_en   = 1'b1;
                push_data = pc_in[DATA_W-1:0];
            end
            if (step_q == S_PFL) begin
                push_en   = 1'b1;
                push_data = flags_in;
            end
            if (step_q == S_CLR) begin
                flags_load = 1'b1;
                flags_next = '0;
            end
            if (step_q == ENTRY_LAST) begin
                pc_load = 1'b1;
                pc_next = {{DATA_W{1'b0}}, irq_vec};
                irq_ack = 1'b1;
            end
        end else if (state_q == ST_RETURN) begin
            pop_en = 1'b1;
            if (step_q == RET_LAST) begin
                pc_load    = 1'b1;
                pc_next    = {stk_rdata, pcl_buf_q};
                flags_load = 1'b1;
                flags_next = flg_buf_q;
            end
        end
    end

    // R1: the core is only stalled after a boundary
    assert_start_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_hold) |-> $past(instr_done));

    // R9: a boundary without an enabled request or return leaves the core running
    assert_gated_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_hold && instr_done && !ret_req && !(irq_req && flags_in[GIE_BIT]))
        |=> !core_hold);

    // R6: acknowledge is one cycle long and closes the entry
    assert_ack_closes_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!irq_ack && !core_hold));

    // R12: return wins over a request at the same boundary
    assert_return_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_hold && instr_done && ret_req) |=> (pop_en && !push_en));

endmodule

// File: rtl/irq_seq_stack.sv
// Module irq_seq_stack
// Owns the stack pointer and turns push/pop requests into memory strobes.
// Push writes at the pointer then increments; pop reads at pointer-1 and
// decrements. The pointer wraps in both directions.
// Assumes: push and pop are never requested together.
module irq_seq_stack #(
    parameter int DATA_W = 8,
    parameter int SP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    output logic              stk_we,
    output logic [SP_W-1:0]   stk_waddr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic [SP_W-1:0]   stk_raddr,
    output logic [SP_W-1:0]   sp
);

    logic [SP_W-1:0] sp_q;

    assign sp        = sp_q;
    assign stk_we    = push_en;
    assign stk_waddr = sp_q;
    assign stk_wdata = push_data;
    assign stk_raddr = sp_q - SP_W'(1);

    // Pointer update on push or pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push_en) begin
            sp_q <= sp_q + SP_W'(1);
        end else if (pop_en) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    // R11: pushes and pops never collide
    assert_push_pop_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_en && pop_en));

    // R11: pointer moves up by one after a push, wrapping
    assert_push_moves_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (sp == $past(sp) + SP_W'(1)));

    // R11: pointer moves down by one after a pop, wrapping
    assert_pop_moves_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> (sp == $past(sp) - SP_W'(1)));

endmodule

// File: rtl/irq_seq_latency.sv
// Module irq_seq_latency
// Free-running latency counter: restarts at 1 in the cycle after an enabled
// request first appears, then counts each cycle and saturates.
// Assumes: the request is withdrawn between measurements.
module irq_seq_latency #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic             gie,
    output logic [LAT_W-1:0] lat_cycles
);

    logic             act;
    logic             act_q;
    logic [LAT_W-1:0] lat_q;

    assign act        = irq_req && gie;
    assign lat_cycles = lat_q;

    // Remember whether an enabled request was seen last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // Restart on a new enabled request, otherwise count up to saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (act && !act_q) begin
            lat_q <= LAT_W'(1);
        end else if (lat_q != {LAT_W{1'b1}}) begin
            lat_q <= lat_q + LAT_W'(1);
        end
    end

    // R10: between restarts the count never goes down
    assert_lat_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(act && !act_q) |=> (lat_cycles >= $past(lat_cycles)));

endmodule

// File: rtl/irq_seq_top.sv
// Module irq_seq_top
// Interrupt entry/return sequencer top. Connects step control, the stack
// pointer unit and the latency counter. The stack memory and the core's PC
// and flag registers live outside and follow the load/strobe outputs.
// Assumes: combinational stack read, core loads on the next edge.
module irq_seq_top #(
    parameter int DATA_W    = 8,
    parameter int SP_W      = 8,
    parameter int GIE_BIT   = 0,
    parameter int ENTRY_LEN = 13,
    parameter int LAT_W     = 8,
    localparam int PC_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              ret_req,
    input  logic              irq_req,
    input  logic [DATA_W-1:0] irq_vec,
    output logic              irq_ack,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] flags_in,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_next,
    output logic              flags_load,
    output logic [DATA_W-1:0] flags_next,
    output logic              stk_we,
    output logic [SP_W-1:0]   stk_waddr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic [SP_W-1:0]   stk_raddr,
    input  logic [DATA_W-1:0] stk_rdata,
    output logic [SP_W-1:0]   sp,
    output logic              core_hold,
    output logic [LAT_W-1:0]  lat_cycles
);

    logic              push_en;
    logic [DATA_W-1:0] push_data;
    logic              pop_en;

    irq_seq_ctrl #(
        .DATA_W    (DATA_W),
        .GIE_BIT   (GIE_BIT),
        .ENTRY_LEN (ENTRY_LEN)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .ret_req    (ret_req),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .pc_in      (pc_in),
        .flags_in   (flags_in),
        .stk_rdata  (stk_rdata),
        .push_en    (push_en),
        .push_data  (push_data),
        .pop_en     (pop_en),
        .pc_load    (pc_load),
        .pc_next    (pc_next),
        .flags_load (flags_load),
        .flags_next (flags_next),
        .irq_ack    (irq_ack),
        .core_hold  (core_hold)
    );

    irq_seq_stack #(
        .DATA_W (DATA_W),
        .SP_W   (SP_W)
    ) i_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_data (push_data),
        .pop_en    (pop_en),
        .stk_we    (stk_we),
        .stk_waddr (stk_waddr),
        .stk_wdata (stk_wdata),
        .stk_raddr (stk_raddr),
        .sp        (sp)
    );

    irq_seq_latency #(
        .LAT_W (LAT_W)
    ) i_latency (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .gie        (flags_in[GIE_BIT]),
        .lat_cycles (lat_cycles)
    );

    // R5: a PC load during an acknowledge targets page zero
    assert_vector_page_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (pc_load && pc_next[PC_W-1:DATA_W] == '0));

endmodule

// File: tb/test_irq_seq_top.sv
// Bench for irq_seq_top: models the core PC/flag registers and a 256-byte
// stack, sweeps request arrival over a 5-cycle instruction and checks entry,
// return, chaining, gating, priority and pointer wrap.
module test_irq_seq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_done, ret_req, irq_req;
    logic [7:0]  irq_vec;
    logic        irq_ack, pc_load, flags_load, stk_we, core_hold;
    logic [15:0] pc_next;
    logic [7:0]  flags_next, stk_waddr, stk_wdata, stk_raddr, stk_rdata, sp, lat_cycles;

    logic [7:0]  mem [256];
    logic [15:0] core_pc;
    logic [7:0]  core_f;
    logic        m_set;
    logic [15:0] m_pc;
    logic [7:0]  m_f;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] exp_sp;

    always #5 clk = ~clk;

    // Core register and stack model
    always @(posedge clk) begin
        if (m_set) begin
            core_pc <= m_pc;
            core_f  <= m_f;
        end else begin
            if (pc_load)    core_pc <= pc_next;
            if (flags_load) core_f  <= flags_next;
        end
        if (stk_we) mem[stk_waddr] <= stk_wdata;
    end
    assign stk_rdata = mem[stk_raddr];

    irq_seq_top i_irq_seq_top (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ret_req(ret_req),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
        .pc_in(core_pc), .flags_in(core_f), .pc_load(pc_load), .pc_next(pc_next),
        .flags_load(flags_load), .flags_next(flags_next), .stk_we(stk_we),
        .stk_waddr(stk_waddr), .stk_wdata(stk_wdata), .stk_raddr(stk_raddr),
        .stk_rdata(stk_rdata), .sp(sp), .core_hold(core_hold), .lat_cycles(lat_cycles)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_core(input logic [15:0] p, input logic [7:0] f);
        step();
        m_set = 1'b1; m_pc = p; m_f = f;
        step();
        m_set = 1'b0;
    endtask

    // Count held cycles; drop the request when the acknowledge is seen
    task automatic run_hold(output int n, output int at, output int cnt);
        n = 0; at = 0; cnt = 0;
        for (int g = 0; g < 64; g++) begin
            step();
            instr_done = 1'b0;
            ret_req    = 1'b0;
            if (!core_hold) break;
            n++;
            if (irq_ack) begin
                cnt++;
                at = n;
                irq_req = 1'b0;
            end
        end
    endtask

    task automatic do_ret(output int n, output int at, output int cnt);
        step();
        instr_done = 1'b1;
        ret_req    = 1'b1;
        run_hold(n, at, cnt);
    endtask

    // Entry after a 5-cycle instruction with the request arriving in cycle k
    task automatic lat_case(input int k, input logic [15:0] p, input logic [7:0] f,
                            input logic [7:0] v);
        int n, at, cnt;
        logic [7:0] a0;
        set_core(p, f);
        a0 = exp_sp;
        irq_vec = v;
        for (int j = 1; j <= 5; j++) begin
            step();
            irq_req    = (j >= k);
            instr_done = (j == 5);
        end
        run_hold(n, at, cnt);
        chk("R2", "entry hold cycles", n, 13);
        chk("R6", "ack cycle index", at, 13);
        chk("R6", "ack pulse count", cnt, 1);
        chk("R3", "push pc high", mem[a0], p[15:8]);
        chk("R3", "push pc low", mem[8'(a0 + 8'd1)], p[7:0]);
        chk("R3", "push flags", mem[8'(a0 + 8'd2)], f);
        chk("R11", "sp after entry", sp, 8'(a0 + 8'd3));
        chk("R4", "flags cleared", core_f, 0);
        chk("R5", "pc at vector", core_pc, {8'h00, v});
        for (int j = 2; j <= 7; j++) begin
            step();
            instr_done = (j == 7);
        end
        step();
        instr_done = 1'b0;
        chk("R10", "latency at service start", lat_cycles, 26 - k);
        exp_sp = 8'(a0 + 8'd3);
        do_ret(n, at, cnt);
        chk("R7", "return hold cycles", n, 3);
        chk("R7", "pc restored", core_pc, p);
        chk("R7", "flags restored", core_f, f);
        chk("R11", "sp after return", sp, a0);
        exp_sp = a0;
    endtask

    initial begin
        for (int w = 0; w < 100000; w++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        int n, at, cnt;
        logic [7:0] a0;
        logic       chain;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst_n = 1'b0; instr_done = 1'b0; ret_req = 1'b0; irq_req = 1'b0;
        irq_vec = 8'h00; m_set = 1'b0; m_pc = 16'h0; m_f = 8'h0;
        set_core(16'h0000, 8'h00);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R13: reset state
        chk("R13", "sp after reset", sp, 0);
        chk("R13", "hold after reset", core_hold, 0);
        chk("R13", "ack after reset", irq_ack, 0);
        chk("R13", "stack write after reset", stk_we, 0);
        chk("R13", "loads after reset", {pc_load, flags_load}, 0);

        // R11/R7: return from an empty stack wraps the pointer downwards
        do_ret(n, at, cnt);
        chk("R7", "return hold from reset", n, 3);
        chk("R11", "sp wraps on pop", sp, 8'd253);
        chk("R7", "pc popped zero", core_pc, 0);
        exp_sp = 8'd253;

        // R1: enabled request without a boundary is not taken
        set_core(16'h1234, 8'h01);
        step();
        irq_req = 1'b1;
        for (int j = 0; j < 6; j++) begin
            step();
            chk("R1", "no hold without boundary", core_hold, 0);
        end
        irq_req = 1'b0;
        repeat (2) step();

        // R10 sweep over request arrival; first pass wraps the push (R11)
        for (int k = 1; k <= 5; k++)
            lat_case(k, 16'h1357 + 16'(k * 16'h2111), 8'h01 | 8'(k << 3),
                     8'h04 + 8'(k * 12));

        // R8/R9: pending request during service routine, then chained entry
        set_core(16'h2345, 8'h81);
        a0 = exp_sp;
        irq_vec = 8'h40;
        step();
        irq_req = 1'b1;
        instr_done = 1'b1;
        run_hold(n, at, cnt);
        chk("R2", "first entry hold", n, 13);
        exp_sp = 8'(a0 + 8'd3);
        irq_req = 1'b1;
        irq_vec = 8'h58;
        for (int j = 0; j < 4; j++) begin
            step();
            chk("R9", "no hold with enable clear", core_hold, 0);
            chk("R9", "no stack write with enable clear", stk_we, 0);
            instr_done = 1'b1;
        end
        step();
        instr_done = 1'b0;
        chk("R9", "hold stays low", core_hold, 0);
        chk("R9", "sp unchanged", sp, exp_sp);
        do_ret(n, at, cnt);
        chk("R8", "return plus entry hold", n, 16);
        chk("R8", "ack in chained entry", at, 16);
        chk("R8", "chained push pc high", mem[a0], 8'h23);
        chk("R8", "chained push pc low", mem[8'(a0 + 8'd1)], 8'h45);
        chk("R8", "chained push flags", mem[8'(a0 + 8'd2)], 8'h81);
        chk("R8", "chained vector", core_pc, 16'h0058);
        chk("R11", "sp after chain", sp, exp_sp);
        do_ret(n, at, cnt);
        chk("R7", "final return pc", core_pc, 16'h2345);
        chk("R7", "final return flags", core_f, 8'h81);
        exp_sp = a0;

        // R12: return and enabled request at the same boundary
        set_core(16'h3456, 8'h01);
        a0 = exp_sp;
        chain = mem[8'(a0 - 8'd1)][0];
        irq_vec = 8'h10;
        step();
        irq_req = 1'b1;
        instr_done = 1'b1;
        ret_req = 1'b1;
        step();
        instr_done = 1'b0;
        ret_req = 1'b0;
        chk("R12", "held on shared boundary", core_hold, 1);
        step();
        chk("R12", "pop came first", sp, 8'(a0 - 8'd1));
        run_hold(n, at, cnt);
        irq_req = 1'b0;
        chk("R12", "total hold", n + 2, chain ? 16 : 3);
        chk("R12", "sp after shared boundary", sp, chain ? a0 : 8'(a0 - 8'd3));

        report();
    end

endmodule